// File: doc/BRIEF.md
# Flash Command Decoder and Status Register

This block is the command front end of a block-erasable flash memory. The host writes command bytes, together with an address, over bus write cycles. The block decodes each byte in the light of its current state. It chooses what a bus read returns: array data, the status byte or the identifier. It launches program and block-erase jobs on a sequencer handshake and keeps a status byte that reports readiness, suspension and sticky failure flags. The array itself, the program and erase algorithms and the supply sensing sit outside the block. They appear only as the `job_*`, `seq_*` and `vpp_ok` signals.

The controller is a single state machine with seven states:

- ST_READY: idle, read mode selectable.
- ST_PROG_SETUP: waiting for the program data write.
- ST_PROG_BUSY: program job running.
- ST_ERASE_SETUP: waiting for the confirm byte.
- ST_ERASE_BUSY: erase job running.
- ST_SUSP_PEND: suspend requested, waiting for the sequencer to pause.
- ST_SUSPENDED: erase paused.

Its transitions are:

- ST_READY goes to ST_PROG_SETUP on 0x40 and to ST_ERASE_SETUP on 0x20.
- ST_PROG_SETUP goes to ST_PROG_BUSY on a data write with the supply valid, or back to ST_READY with the supply flag set.
- ST_ERASE_SETUP goes to ST_ERASE_BUSY on 0xD0 with the supply valid. It goes to ST_READY on 0xD0 with the supply low, or on any other byte (abort).
- Either busy state goes to ST_READY on `seq_done`.
- ST_ERASE_BUSY goes to ST_SUSP_PEND on 0xB0.
- ST_SUSP_PEND goes to ST_SUSPENDED on `seq_susp_ack`, or to ST_READY on `seq_done`.
- ST_SUSPENDED goes back to ST_ERASE_BUSY on 0xD0.

Command codes: 0xFF array read, 0x70 status read, 0x50 clear status, 0x90 identifier read, 0x40 program setup, 0x20 erase setup, 0xD0 erase confirm or resume, 0xB0 erase suspend. The read selector `rd_sel` encodes 0 = array, 1 = status and 2 = identifier. The job type `job_kind` is 0 for a program and 1 for an erase.

The status byte is laid out as follows:

| Bit | Meaning |
|---|---|
| 7 | Ready |
| 6 | Erase suspended |
| 5 | Erase failure |
| 4 | Program failure |
| 3 | Supply error |
| 2:0 | Always 0 |

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset `rd_sel` is 0 (array), `status_out` is 0x80, and `job_req` and `susp_req` are 0.
- R2: In ST_READY, a write of 0xFF, 0x70 or 0x90 sets `rd_sel` to 0, 1 or 2 respectively, and the new selection is visible after the write's clock edge.
- R3: With `vpp_ok` high, a write of 0x40 followed by a data write raises `job_req` for exactly one cycle. During that cycle `job_kind` is 0 and `job_addr`/`job_data` carry the second write's address and byte. Status bit 7 is 0 until `seq_done`, and `rd_sel` is 1.
- R4: While a program job runs, every write other than 0x70 is ignored. `rd_sel`, the status flags and `job_req` are unchanged.
- R5: If `vpp_ok` is low at the program data write, no job starts, status bit 3 becomes 1 and the block returns to ST_READY (status 0x88 from clean).
- R6: A write of 0x20 followed by 0xD0 with `vpp_ok` high launches an erase job (`job_kind` 1). `job_addr` carries the address of the confirm write.
- R7: If `vpp_ok` is low at the confirm write, no job starts and status bits 5 and 3 become 1 (status 0xA8 from clean).
- R8: After 0x20, any byte other than 0xD0 aborts the erase: no job starts, status bits 5 and 4 become 1 (0xB0 from clean) and `rd_sel` is 1.
- R9: `seq_done` with `seq_fail` high sets status bit 4 for a program job and bit 5 for an erase job. With `seq_fail` low, no flag changes.
- R10: Failure bits 5..3 stay set through any other command and are cleared only by 0x50 written in ST_READY.
- R11: A write of 0xB0 during an erase raises `susp_req`. Once the sequencer acknowledges, status reads 0xC0 (ready and suspended). In that state only 0xFF, 0x70 and 0xD0 act, and 0xD0 drops `susp_req` and returns status bit 7 to 0.
- R12: When a job completes, `rd_sel` stays 1 (status) until a 0xFF write returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Address of the bus write |
| wr_data | input | 8 | Command or program data byte |
| vpp_ok | input | 1 | Programming supply within limits |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 identifier |
| status_out | output | 8 | Status byte |
| job_req | output | 1 | One-cycle job launch pulse |
| job_kind | output | 1 | 0 program, 1 erase |
| job_addr | output | ADDR_W | Target address of the launched job |
| job_data | output | 8 | Program data byte |
| susp_req | output | 1 | Erase pause request, held while suspending or suspended |
| seq_done | input | 1 | Sequencer finished the current job (one-cycle pulse) |
| seq_fail | input | 1 | Job failed, valid with seq_done |
| seq_susp_ack | input | 1 | Sequencer is paused |

## Verification
The bench tests the commands under two kinds of stimulus. Directed sequences cover successful and failing jobs, both supply-error paths, the erase abort and a full suspend/resume. They separate the state-dependent legality rules from plain decoding. A seeded random stream of command bytes, including invalid ones, is then sent with the supply held low so that no job can start. A bench model checks `rd_sel` and the status byte after every write. This stream separates sticky-flag behaviour and setup aborts from ordinary mode switching across arbitrary orderings. A behavioural sequencer stub with a programmable latency and fail result answers the job handshake.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_READY,
        ST_PROG_SETUP,
        ST_PROG_BUSY,
        ST_ERASE_SETUP,
        ST_ERASE_BUSY,
        ST_SUSP_PEND,
        ST_SUSPENDED
    } ctrl_state_e;

    typedef enum logic [3:0] {
        CMD_RD_ARRAY,
        CMD_RD_STATUS,
        CMD_CLR_STATUS,
        CMD_RD_IDENT,
        CMD_PROG_SETUP,
        CMD_ERASE_SETUP,
        CMD_CONFIRM,
        CMD_SUSPEND,
        CMD_OTHER
    } cmd_e;

    typedef enum logic [1:0] {
        SEL_ARRAY  = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_IDENT  = 2'd2
    } rd_sel_e;

    localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_RD_STATUS = 8'h70;
    localparam logic [7:0] OP_CLR       = 8'h50;
    localparam logic [7:0] OP_RD_IDENT  = 8'h90;
    localparam logic [7:0] OP_PROG      = 8'h40;
    localparam logic [7:0] OP_ERASE     = 8'h20;
    localparam logic [7:0] OP_CONFIRM   = 8'hD0;
    localparam logic [7:0] OP_SUSPEND   = 8'hB0;

    localparam int FLAG_N = 3;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] op_byte,
    output cmd_e       op_cmd
);
    always_comb begin
        unique case (op_byte)
            OP_RD_ARRAY:  op_cmd = CMD_RD_ARRAY;
            OP_RD_STATUS: op_cmd = CMD_RD_STATUS;
            OP_CLR:       op_cmd = CMD_CLR_STATUS;
            OP_RD_IDENT:  op_cmd = CMD_RD_IDENT;
            OP_PROG:      op_cmd = CMD_PROG_SETUP;
            OP_ERASE:     op_cmd = CMD_ERASE_SETUP;
            OP_CONFIRM:   op_cmd = CMD_CONFIRM;
            OP_SUSPEND:   op_cmd = CMD_SUSPEND;
            default:      op_cmd = CMD_OTHER;
        endcase
    end
endmodule

// File: rtl/flash_status_flags.sv
module flash_status_flags
    import flash_cmd_pkg::*;
#(
    parameter int N = FLAG_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_all,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (clr_all)    flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              vpp_ok,
    output logic [1:0]        rd_sel,
    output logic [7:0]        status_out,
    output logic              job_req,
    output logic              job_kind,
    output logic [ADDR_W-1:0] job_addr,
    output logic [7:0]        job_data,
    output logic              susp_req,
    input  logic              seq_done,
    input  logic              seq_fail,
    input  logic              seq_susp_ack
);
    localparam int F_VPP = 0;
    localparam int F_PF  = 1;
    localparam int F_EF  = 2;

    ctrl_state_e state_q, state_d;
    rd_sel_e     sel_q, sel_d;
    cmd_e        cmd;
    logic        launch, launch_erase, clr;
    logic [FLAG_N-1:0] set_vec, flags;

    flash_cmd_decode u_dec (.op_byte(wr_data), .op_cmd(cmd));

    flash_status_flags #(.N(FLAG_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_all(clr), .flags(flags)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        sel_d        = sel_q;
        launch       = 1'b0;
        launch_erase = 1'b0;
        clr          = 1'b0;
        set_vec      = '0;
        unique case (state_q)
            ST_READY: begin
                if (wr_en) begin
                    unique case (cmd)
                        CMD_RD_ARRAY:   sel_d = SEL_ARRAY;
                        CMD_RD_STATUS:  sel_d = SEL_STATUS;
                        CMD_RD_IDENT:   sel_d = SEL_IDENT;
                        CMD_CLR_STATUS: clr = 1'b1;
                        CMD_PROG_SETUP: begin
                            state_d = ST_PROG_SETUP;
                            sel_d   = SEL_STATUS;
                        end
                        CMD_ERASE_SETUP: begin
                            state_d = ST_ERASE_SETUP;
                            sel_d   = SEL_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PROG_SETUP: begin
                if (wr_en) begin
                    sel_d = SEL_STATUS;
                    if (vpp_ok) begin
                        launch  = 1'b1;
                        state_d = ST_PROG_BUSY;
                    end else begin
                        set_vec[F_VPP] = 1'b1;
                        state_d        = ST_READY;
                    end
                end
            end
            ST_PROG_BUSY: begin
                if (seq_done) begin
                    set_vec[F_PF] = seq_fail;
                    state_d       = ST_READY;
                end else if (wr_en && cmd == CMD_RD_STATUS) begin
                    sel_d = SEL_STATUS;
                end
            end
            ST_ERASE_SETUP: begin
                if (wr_en) begin
                    sel_d   = SEL_STATUS;
                    state_d = ST_READY;
                    if (cmd == CMD_CONFIRM) begin
                        if (vpp_ok) begin
                            launch       = 1'b1;
                            launch_erase = 1'b1;
                            state_d      = ST_ERASE_BUSY;
                        end else begin
                            set_vec[F_VPP] = 1'b1;
                            set_vec[F_EF]  = 1'b1;
                        end
                    end else begin
                        set_vec[F_PF] = 1'b1;
                        set_vec[F_EF] = 1'b1;
                    end
                end
            end
            ST_ERASE_BUSY: begin
                if (seq_done) begin
                    set_vec[F_EF] = seq_fail;
                    state_d       = ST_READY;
                end else if (wr_en) begin
                    if (cmd == CMD_SUSPEND)        state_d = ST_SUSP_PEND;
                    else if (cmd == CMD_RD_STATUS) sel_d   = SEL_STATUS;
                end
            end
            ST_SUSP_PEND: begin
                if (seq_done) begin
                    set_vec[F_EF] = seq_fail;
                    state_d       = ST_READY;
                end else if (seq_susp_ack) begin
                    state_d = ST_SUSPENDED;
                end
            end
            ST_SUSPENDED: begin
                if (wr_en) begin
                    unique case (cmd)
                        CMD_RD_ARRAY:  sel_d = SEL_ARRAY;
                        CMD_RD_STATUS: sel_d = SEL_STATUS;
                        CMD_CONFIRM: begin
                            sel_d   = SEL_STATUS;
                            state_d = ST_ERASE_BUSY;
                        end
                        default: ;
                    endcase
                end
            end
            default: state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= SEL_ARRAY;
            job_req  <= 1'b0;
            job_kind <= 1'b0;
            job_addr <= '0;
            job_data <= '0;
        end else begin
            sel_q   <= sel_d;
            job_req <= launch;
            if (launch) begin
                job_kind <= launch_erase;
                job_addr <= wr_addr;
                job_data <= wr_data;
            end
        end
    end

    logic ready;
    always_comb begin
        ready = !(state_q == ST_PROG_BUSY || state_q == ST_ERASE_BUSY ||
                  state_q == ST_SUSP_PEND);
        status_out = {ready, (state_q == ST_SUSPENDED), flags[F_EF],
                      flags[F_PF], flags[F_VPP], 3'b000};
        susp_req   = (state_q == ST_SUSP_PEND) || (state_q == ST_SUSPENDED);
        rd_sel     = sel_q;
    end

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       vpp_ok,
    input logic       job_req,
    input logic [7:0] status_out,
    input logic       susp_req
);
    // R5 R7
    job_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_req |-> $past(vpp_ok));

    // R3
    job_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_req |=> !job_req);

    // R3
    job_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_req |-> !status_out[7]);

    // R10
    pfail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_out[4]) |-> $past(wr_en && wr_data == 8'h50));

    // R10
    efail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_out[5]) |-> $past(wr_en && wr_data == 8'h50));

    // R10
    vpp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_out[3]) |-> $past(wr_en && wr_data == 8'h50));

    // R11
    susp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_out[6] |-> (susp_req && status_out[7]));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .vpp_ok(vpp_ok), .job_req(job_req), .status_out(status_out),
    .susp_req(susp_req)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          vpp_ok = 1'b1;
    logic [1:0]    rd_sel;
    logic [7:0]    status_out;
    logic          job_req, job_kind, susp_req;
    logic [AW-1:0] job_addr;
    logic [7:0]    job_data;
    logic          seq_done = 1'b0, seq_fail = 1'b0, seq_susp_ack = 1'b0;

    int n_tests = 0, n_fail = 0, n_jobs = 0, cycles = 0;
    int cfg_lat = 6;
    bit cfg_fail = 1'b0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vpp_ok(vpp_ok), .rd_sel(rd_sel),
        .status_out(status_out), .job_req(job_req), .job_kind(job_kind),
        .job_addr(job_addr), .job_data(job_data), .susp_req(susp_req),
        .seq_done(seq_done), .seq_fail(seq_fail), .seq_susp_ack(seq_susp_ack)
    );

    // behavioural sequencer stub
    int  stub_cnt = 0;
    bit  stub_busy = 1'b0;
    always @(posedge clk) begin
        seq_done <= 1'b0;
        if (job_req) begin
            n_jobs    <= n_jobs + 1;
            stub_busy <= 1'b1;
            stub_cnt  <= cfg_lat;
        end else if (stub_busy && !susp_req) begin
            if (stub_cnt == 0) begin
                seq_done  <= 1'b1;
                seq_fail  <= cfg_fail;
                stub_busy <= 1'b0;
            end else begin
                stub_cnt <= stub_cnt - 1;
            end
        end
        seq_susp_ack <= stub_busy && susp_req;
    end

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] b, logic [AW-1:0] a = '0);
        wr_en = 1'b1; wr_data = b; wr_addr = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 500; i++) begin
            if (status_out[7]) break;
            @(negedge clk);
        end
    endtask

    // bench model for the random phase (supply held low)
    int unsigned m_st;
    int unsigned m_sel;
    logic [2:0]  m_flags;

    function automatic logic [7:0] exp_status(logic [2:0] f);
        return {2'b10, f, 3'b000};
    endfunction

    task automatic model_step(logic [7:0] b);
        case (m_st)
            0: begin
                case (b)
                    8'hFF: m_sel = 0;
                    8'h70: m_sel = 1;
                    8'h90: m_sel = 2;
                    8'h50: m_flags = 3'b000;
                    8'h40: begin m_st = 1; m_sel = 1; end
                    8'h20: begin m_st = 2; m_sel = 1; end
                    default: ;
                endcase
            end
            1: begin m_flags[0] = 1'b1; m_st = 0; m_sel = 1; end
            default: begin
                if (b == 8'hD0) m_flags = m_flags | 3'b101;
                else            m_flags = m_flags | 3'b110;
                m_st = 0; m_sel = 1;
            end
        endcase
    endtask

    initial begin
        int jobs0;
        logic [7:0] codes [9];
        codes = '{8'hFF, 8'h70, 8'h50, 8'h90, 8'h40, 8'h20, 8'hD0, 8'hB0, 8'h00};
        void'($urandom(32'h5EED_0042));
        idle(3);
        // R1 reset state
        check("R1 rd_sel", rd_sel, 0);
        check("R1 status", status_out, 8'h80);
        check("R1 job_req", job_req, 0);
        check("R1 susp_req", susp_req, 0);
        rst_n = 1'b1;
        idle(1);

        // R2 read mode selection
        wr(8'h70); check("R2 status select", rd_sel, 1);
        wr(8'h90); check("R2 ident select", rd_sel, 2);
        wr(8'hFF); check("R2 array select", rd_sel, 0);

        // R3 successful program
        cfg_lat = 6; cfg_fail = 1'b0;
        wr(8'h40);
        wr(8'h5A, 18'h00123);
        check("R3 job_req", job_req, 1);
        check("R3 job_kind", job_kind, 0);
        check("R3 job_addr", job_addr, 18'h00123);
        check("R3 job_data", job_data, 8'h5A);
        check("R3 busy bit", status_out[7], 0);
        check("R3 rd_sel", rd_sel, 1);
        idle(1);
        check("R3 single pulse", job_req, 0);
        // R4 writes ignored while programming
        jobs0 = n_jobs;
        wr(8'hFF); check("R4 array ignored", rd_sel, 1);
        wr(8'h40); wr(8'h11);
        check("R4 no new job", n_jobs, jobs0);
        check("R4 still busy", status_out, 8'h00);
        wr(8'h70); check("R4 status accepted", rd_sel, 1);
        wait_ready();
        check("R9 clean program", status_out, 8'h80);
        check("R12 stays status", rd_sel, 1);
        wr(8'hFF); check("R12 array after FF", rd_sel, 0);

        // R9 failing program, R10 sticky
        cfg_fail = 1'b1;
        wr(8'h40); wr(8'hA5, 18'h00040);
        wait_ready();
        check("R9 program fail bit", status_out, 8'h90);
        wr(8'h70); wr(8'hFF); wr(8'h90);
        check("R10 sticky program fail", status_out, 8'h90);
        wr(8'h50);
        check("R10 cleared", status_out, 8'h80);

        // R5 supply low on program
        jobs0 = n_jobs; vpp_ok = 1'b0;
        wr(8'h40); wr(8'h33, 18'h00007);
        idle(2);
        check("R5 supply error", status_out, 8'h88);
        check("R5 no job", n_jobs, jobs0);
        check("R5 rd_sel", rd_sel, 1);
        // R7 supply low at confirm
        wr(8'h50);
        wr(8'h20); wr(8'hD0, 18'h20000);
        idle(2);
        check("R7 erase supply error", status_out, 8'hA8);
        check("R7 no job", n_jobs, jobs0);
        vpp_ok = 1'b1;
        // R8 abort
        wr(8'h50);
        wr(8'h20); wr(8'h77);
        idle(2);
        check("R8 abort status", status_out, 8'hB0);
        check("R8 abort no job", n_jobs, jobs0);
        check("R8 abort rd_sel", rd_sel, 1);
        wr(8'h50);

        // R6 erase, R9 erase fail
        cfg_fail = 1'b1; cfg_lat = 5;
        wr(8'h20, 18'h00001);
        wr(8'hD0, 18'h13456);
        check("R6 job_req", job_req, 1);
        check("R6 job_kind", job_kind, 1);
        check("R6 confirm address", job_addr, 18'h13456);
        wait_ready();
        check("R9 erase fail bit", status_out, 8'hA0);
        wr(8'h50);

        // R11 suspend and resume
        cfg_fail = 1'b0; cfg_lat = 30;
        wr(8'h20); wr(8'hD0, 18'h08000);
        idle(3);
        wr(8'hB0);
        check("R11 susp_req", susp_req, 1);
        idle(4);
        check("R11 suspended status", status_out, 8'hC0);
        jobs0 = n_jobs;
        wr(8'h40); wr(8'h20);
        check("R11 setup ignored", status_out, 8'hC0);
        check("R11 no new job", n_jobs, jobs0);
        wr(8'hFF); check("R11 array read", rd_sel, 0);
        wr(8'h90); check("R11 ident ignored", rd_sel, 0);
        wr(8'h50); check("R11 clear ignored", status_out, 8'hC0);
        wr(8'hD0);
        check("R11 resumed busy", status_out, 8'h00);
        check("R11 susp_req drop", susp_req, 0);
        wait_ready();
        check("R11 erase finished", status_out, 8'h80);
        check("R12 after erase", rd_sel, 1);

        // random phase, supply low so no job can start
        vpp_ok = 1'b0;
        wr(8'hFF); wr(8'h50);
        m_st = 0; m_sel = 0; m_flags = 3'b000;
        jobs0 = n_jobs;
        for (int i = 0; i < 200; i++) begin
            logic [7:0] b;
            b = ($urandom % 4 == 0) ? 8'($urandom) : codes[$urandom % 9];
            model_step(b);
            wr(b, AW'($urandom));
            check("R2 R10 random rd_sel", rd_sel, m_sel);
            check("R10 random status", status_out, exp_status(m_flags));
        end
        check("R5 random no jobs", n_jobs, jobs0);

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done_flag) begin
            done_flag = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule